// File: doc/BRIEF.md
# Non-uniform carry-select adder

This block adds two 32-bit operands and a carry input in one combinational pass, giving a 32-bit sum and a carry output. The operand bits are cut into seven groups of unequal width, 2, 2, 3, 4, 6, 7 and 8 bits going from the least significant end. Narrow groups sit at the low end, where the incoming carry settles first. Wider groups sit at the high end, where there is more time before their select arrives.

The lowest group is a plain ripple-carry adder driven by the external carry input. Each higher group adds its slice with a carry-in of zero. It also forms the result it would give with a carry-in of one. A 2:1 selection then picks one of the two, steered by the carry leaving the group below.

A style parameter chooses how the carry-in-of-one result is made. In the default style, an (n+1)-bit incrementer adds one to the n-bit sum and its group carry. In the dual-ripple style, a second ripple adder with its carry input tied high produces that result. The carry output of the whole adder is the selected carry of the top group.

Top module: `csa_nonuniform_adder`

## Requirements
- R1: In the incrementer style (STYLE = STYLE_INC), {cout, sum} equals a + b + cin taken as a 33-bit value, for every operand pattern.
- R2: In the dual-ripple style (STYLE = STYLE_DUAL), {cout, sum} equals a + b + cin taken as a 33-bit value, for every operand pattern.
- R3: The groups occupy bit ranges [1:0], [3:2], [6:4], [10:7], [16:11], [23:17] and [31:24]. A carry generated below any group boundary at bit 2, 4, 7, 11, 17 or 24 reaches the bits above it.
- R4: The external carry input enters only the lowest group, so a = 0, b = 0, cin = 1 gives sum = 1 and cout = 0.
- R5: For every higher group, the carry-in-one result {carry, sum} equals the carry-in-zero result plus one, as an (n+1)-bit value.
- R6: For every higher group, the carry-in-one carry is 1 whenever the carry-in-zero carry is 1.
- R7: cout is the selected carry of the most significant group: a = 0xFFFFFFFF, b = 0, cin = 1 gives sum = 0 and cout = 1.
- R8: a = b = 0xFFFFFFFF gives sum = 0xFFFFFFFE + cin and cout = 1.
- R9: Alternating operands 0x55555555 and 0xAAAAAAAA give sum = 0xFFFFFFFF and cout = 0 with cin = 0. With cin = 1 they give sum = 0 and cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input     | 32    | First operand |
| b    | input     | 32    | Second operand |
| cin  | input     | 1     | Carry into bit 0 |
| sum  | output    | 32    | Sum bits |
| cout | output    | 1     | Carry out of bit 31 |

## Verification
The assertions check several things whenever inputs change. Each ripple segment matches the arithmetic sum of its own inputs. Each higher group's carry-in-one result is exactly one more than its carry-in-zero result, and that group's two carries are ordered. The full 33-bit result matches a + b + cin. Some behaviour is visible only at the ports, and only the bench's directed and random scenarios can show it. That covers the exact placement of the group boundaries and a carry crossing each of them. It also covers the end-to-end carry through all seven groups, and the agreement of both build styles on the same stimulus.

// File: rtl/csa_pkg.sv
package csa_pkg;
  typedef enum logic {
    STYLE_INC  = 1'b0,
    STYLE_DUAL = 1'b1
  } csa_style_e;
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         co
);
  logic [N:0] c;
  assign c[0] = ci;

  for (genvar k = 0; k < N; k++) begin : g_fa
    assign s[k]   = a[k] ^ b[k] ^ c[k];
    assign c[k+1] = (a[k] & b[k]) | (c[k] & (a[k] ^ b[k]));
  end

  assign co = c[N];

  always_comb begin
    AST_RIPPLE_SUM: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci}))
      else $error("ripple segment result mismatch"); // R1
  end
endmodule

// File: rtl/csa_inc1.sv
module csa_inc1 #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N:0] ones_below;
  assign ones_below[0] = 1'b1;

  for (genvar k = 0; k < N; k++) begin : g_bit
    assign dout[k]         = din[k] ^ ones_below[k];
    assign ones_below[k+1] = ones_below[k] & din[k];
  end

  always_comb begin
    AST_INC_CHANGES: assert (dout != din)
      else $error("incrementer left value unchanged"); // R5
  end
endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int unsigned        N     = 4,
  parameter csa_pkg::csa_style_e STYLE = csa_pkg::STYLE_INC
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sel,
  output logic [N-1:0] s,
  output logic         co
);
  logic [N-1:0] s_zero, s_one;
  logic         c_zero, c_one;

  csa_ripple #(.N(N)) u_rz (
    .a(a), .b(b), .ci(1'b0), .s(s_zero), .co(c_zero)
  );

  if (STYLE == csa_pkg::STYLE_INC) begin : g_inc
    csa_inc1 #(.N(N+1)) u_inc (
      .din({c_zero, s_zero}), .dout({c_one, s_one})
    );
  end else begin : g_dual
    csa_ripple #(.N(N)) u_ro (
      .a(a), .b(b), .ci(1'b1), .s(s_one), .co(c_one)
    );
  end

  assign s  = sel ? s_one : s_zero;
  assign co = sel ? c_one : c_zero;

  always_comb begin
    AST_PLUS_ONE: assert ({c_one, s_one} == ({c_zero, s_zero} + {{N{1'b0}}, 1'b1}))
      else $error("carry-in-one result is not carry-in-zero plus one"); // R5
    AST_CARRY_ORDER: assert (!c_zero || c_one)
      else $error("carry-in-one carry below carry-in-zero carry"); // R6
  end
endmodule

// File: rtl/csa_nonuniform_adder.sv
module csa_nonuniform_adder #(
  parameter int unsigned         WIDTH   = 32,
  parameter int unsigned         NUM_GRP = 7,
  parameter int unsigned         GRP_W [NUM_GRP] = '{2, 2, 3, 4, 6, 7, 8},
  parameter csa_pkg::csa_style_e STYLE   = csa_pkg::STYLE_INC
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  function automatic int unsigned grp_lo(input int unsigned g);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < g; i++) acc += GRP_W[i];
    return acc;
  endfunction

  logic [NUM_GRP:0] gc;
  assign gc[0] = cin;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int unsigned LO = grp_lo(g);
    localparam int unsigned W  = GRP_W[g];
    if (g == 0) begin : g_base
      csa_ripple #(.N(W)) u_base (
        .a(a[LO +: W]), .b(b[LO +: W]), .ci(gc[g]),
        .s(sum[LO +: W]), .co(gc[g+1])
      );
    end else begin : g_sel
      csa_group #(.N(W), .STYLE(STYLE)) u_grp (
        .a(a[LO +: W]), .b(b[LO +: W]), .sel(gc[g]),
        .s(sum[LO +: W]), .co(gc[g+1])
      );
    end
  end

  assign cout = gc[NUM_GRP];

  always_comb begin
    AST_TOTAL_SUM: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("adder total mismatch"); // R1
  end
endmodule

// File: tb/csa_nonuniform_adder_test.sv
module csa_nonuniform_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] a, b, sum_i, sum_d;
  logic        cin, cout_i, cout_d;
  int total = 0;
  int bad   = 0;

  csa_nonuniform_adder #(.STYLE(csa_pkg::STYLE_INC)) uut (
    .a(a), .b(b), .cin(cin), .sum(sum_i), .cout(cout_i)
  );
  csa_nonuniform_adder #(.STYLE(csa_pkg::STYLE_DUAL)) uut_dual (
    .a(a), .b(b), .cin(cin), .sum(sum_d), .cout(cout_d)
  );

  function automatic logic [32:0] ref_add(input logic [31:0] x, input logic [31:0] y,
                                          input logic c);
    return {1'b0, x} + {1'b0, y} + {32'd0, c};
  endfunction

  task automatic check(input string tag, input logic [31:0] x, input logic [31:0] y,
                       input logic c);
    logic [32:0] exp;
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    exp = ref_add(x, y, c);
    total++;
    if ({cout_i, sum_i} !== exp) begin
      bad++;
      $display("FAIL R1 %s: a=%h b=%h cin=%b got %h exp %h", tag, x, y, c, {cout_i, sum_i}, exp);
    end
    total++;
    if ({cout_d, sum_d} !== exp) begin
      bad++;
      $display("FAIL R2 %s: a=%h b=%h cin=%b got %h exp %h", tag, x, y, c, {cout_d, sum_d}, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bnd [6];
    a = '0; b = '0; cin = 1'b0;
    bnd = '{2, 4, 7, 11, 17, 24};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time state: zero inputs
    check("zero R1", 32'd0, 32'd0, 1'b0);
    check("cin only R4", 32'd0, 32'd0, 1'b1);
    // R3 / R5: carry crossing each group boundary, generated or propagated
    for (int i = 0; i < 6; i++) begin
      check("boundary propagate R3 R5", (32'd1 << bnd[i]) - 32'd1, 32'd0, 1'b1);
      check("boundary generate R3 R5", 32'd1 << (bnd[i] - 1), 32'd1 << (bnd[i] - 1), 1'b0);
      check("boundary stop R3", (32'd1 << bnd[i]) - 32'd1, 32'd0, 1'b0);
    end
    check("full propagate R6 R7", 32'hFFFF_FFFF, 32'd0, 1'b1);
    check("full propagate swap R6 R7", 32'd0, 32'hFFFF_FFFF, 1'b1);
    check("all ones R8", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    check("all ones cin R8", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    check("alternating R9", 32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
    check("alternating cin R9", 32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    check("alternating self R9", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++)
      check("random R1", $urandom(), $urandom(), 1'($urandom() & 1));
    for (int i = 0; i < 200; i++) begin
      logic [31:0] x;
      x = $urandom();
      check("complement R6", x, ~x, 1'($urandom() & 1));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule